// File: doc/BRIEF.md
# Operand Bypass and Load-Use Interlock Control

This block steers the two ALU operands of a five-stage in-order pipeline. For each operand entering the execute stage it compares the source register number against the destinations of the two older instructions still in flight. It then picks one of three sources: the register file value, the ALU result sitting in the register after execute, or the value sitting in the register after memory. For that last source it also builds the write-back value, choosing between the memory read data and the ALU result with the instruction's memory-to-register flag.

A load produces its value only at the end of the memory stage. If the instruction immediately behind it reads that value, no forwarding path can supply it in time. The block spots this case while the consumer is in decode and the load is in execute. It then asks the pipeline to freeze the program counter and the fetch/decode register for one cycle and to push an empty slot into execute. On the next cycle the load has moved on to memory, and the normal after-memory forward supplies the value. The operand muxes and the pipeline registers themselves belong to the surrounding datapath.

Top module: `bypass_ctrl`

## Requirements
- R1: Select codes are 2'b00 for the register file, 2'b10 for the after-execute (EX/M) result and 2'b01 for the after-memory (M/WB) value; 2'b11 never appears. An operand whose source equals the EX/M destination, with the EX/M write-enable set and a non-zero destination, gets 2'b10.
- R2: When there is no EX/M hit, an operand whose source equals the M/WB destination, with the M/WB write-enable set and a non-zero destination, gets 2'b01.
- R3: When both EX/M and M/WB hit for the same operand, the select is 2'b10, because the newer result wins.
- R4: A destination of register 0, or a stage whose write-enable is clear, never causes a forward. With no valid hit the select is 2'b00.
- R5: The second operand, which carries a store's base or data register, is decoded by the same rules as the first and independently of it.
- R6: The forwarded M/WB value equals the memory read data when memory-to-register is 1, and the M/WB ALU result when it is 0.
- R7: When the execute stage holds a load with a non-zero destination equal to either decode-stage source, the PC hold, the fetch/decode hold and the execute bubble are all 1.
- R8: Without a load in execute, or when the load's destination is register 0 or matches neither decode source, all three stall outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_rs1_i | input | AW | Execute-stage first source register |
| ex_rs2_i | input | AW | Execute-stage second source register |
| exm_rd_i | input | AW | EX/M destination register |
| exm_we_i | input | 1 | EX/M register write-enable |
| mwb_rd_i | input | AW | M/WB destination register |
| mwb_we_i | input | 1 | M/WB register write-enable |
| mwb_mem2reg_i | input | 1 | M/WB write-back takes memory data |
| mwb_alu_i | input | DW | M/WB ALU result |
| mwb_rdata_i | input | DW | M/WB memory read data |
| id_rs1_i | input | AW | Decode-stage first source register |
| id_rs2_i | input | AW | Decode-stage second source register |
| ex_rd_i | input | AW | Execute-stage destination register |
| ex_memrd_i | input | 1 | Execute-stage instruction is a load |
| fwd_a_o | output | 2 | First operand source select |
| fwd_b_o | output | 2 | Second operand source select |
| mwb_fwd_o | output | DW | Value forwarded from M/WB |
| pc_hold_o | output | 1 | Keep the PC for one cycle |
| ifid_hold_o | output | 1 | Keep the fetch/decode register for one cycle |
| ex_bubble_o | output | 1 | Zero the control fields entering execute |

## Verification
The hardest case to reach is a double hit. In that case both older stages write the same non-zero register that an operand reads, and the priority order decides the result. A random stream seldom lines up three equal register numbers and two set enables. The bench therefore uses a three-bit register space and sweeps every combination of source, both destinations and both enables, so every double hit, every register-0 case and every disabled-stage case occurs. The load-use detector gets the same full sweep over both decode sources, the load destination and the load flag.

// File: rtl/bypass_pkg.sv
package bypass_pkg;
  typedef enum logic [1:0] {
    SRC_RF  = 2'b00,
    SRC_MWB = 2'b01,
    SRC_EXM = 2'b10
  } src_sel_e;
endpackage

// File: rtl/operand_sel.sv
module operand_sel
  import bypass_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic [AW-1:0] rs_i,
  input  logic [AW-1:0] exm_rd_i,
  input  logic          exm_we_i,
  input  logic [AW-1:0] mwb_rd_i,
  input  logic          mwb_we_i,
  output src_sel_e      sel_o
);
  localparam logic [AW-1:0] ZERO_REG = '0;

  logic exm_hit, mwb_hit;

  assign exm_hit = exm_we_i && (exm_rd_i != ZERO_REG) && (exm_rd_i == rs_i);
  assign mwb_hit = mwb_we_i && (mwb_rd_i != ZERO_REG) && (mwb_rd_i == rs_i);

  always_comb begin
    if (exm_hit)      sel_o = SRC_EXM;
    else if (mwb_hit) sel_o = SRC_MWB;
    else              sel_o = SRC_RF;
  end

  always_comb begin
    // R1
    sel_legal_chk: assert (sel_o != src_sel_e'(2'b11));
    // R4
    zero_reg_chk: assert (!(rs_i == ZERO_REG && sel_o != SRC_RF));
    // R3
    newest_wins_chk: assert (!(sel_o == SRC_MWB && exm_we_i && exm_rd_i == rs_i && rs_i != ZERO_REG));
  end
endmodule

// File: rtl/load_use_detect.sv
module load_use_detect #(
  parameter int AW = 5
) (
  input  logic [AW-1:0] id_rs1_i,
  input  logic [AW-1:0] id_rs2_i,
  input  logic [AW-1:0] ex_rd_i,
  input  logic          ex_memrd_i,
  output logic          stall_o
);
  localparam logic [AW-1:0] ZERO_REG = '0;

  logic dep;
  assign dep     = (ex_rd_i == id_rs1_i) || (ex_rd_i == id_rs2_i);
  assign stall_o = ex_memrd_i && (ex_rd_i != ZERO_REG) && dep;

  always_comb begin
    // R8
    no_load_no_stall_chk: assert (ex_memrd_i || !stall_o);
  end
endmodule

// File: rtl/bypass_ctrl.sv
module bypass_ctrl
  import bypass_pkg::*;
#(
  parameter int AW = 5,
  parameter int DW = 32
) (
  input  logic [AW-1:0] ex_rs1_i,
  input  logic [AW-1:0] ex_rs2_i,
  input  logic [AW-1:0] exm_rd_i,
  input  logic          exm_we_i,
  input  logic [AW-1:0] mwb_rd_i,
  input  logic          mwb_we_i,
  input  logic          mwb_mem2reg_i,
  input  logic [DW-1:0] mwb_alu_i,
  input  logic [DW-1:0] mwb_rdata_i,
  input  logic [AW-1:0] id_rs1_i,
  input  logic [AW-1:0] id_rs2_i,
  input  logic [AW-1:0] ex_rd_i,
  input  logic          ex_memrd_i,
  output logic [1:0]    fwd_a_o,
  output logic [1:0]    fwd_b_o,
  output logic [DW-1:0] mwb_fwd_o,
  output logic          pc_hold_o,
  output logic          ifid_hold_o,
  output logic          ex_bubble_o
);
  localparam int NOPS = 2;

  logic [AW-1:0] rs   [NOPS];
  src_sel_e      sel  [NOPS];
  logic          stall;

  assign rs[0] = ex_rs1_i;
  assign rs[1] = ex_rs2_i;

  for (genvar g = 0; g < NOPS; g++) begin : g_op
    operand_sel #(.AW(AW)) u_sel (
      .rs_i     (rs[g]),
      .exm_rd_i (exm_rd_i),
      .exm_we_i (exm_we_i),
      .mwb_rd_i (mwb_rd_i),
      .mwb_we_i (mwb_we_i),
      .sel_o    (sel[g])
    );
  end

  assign fwd_a_o = sel[0];
  assign fwd_b_o = sel[1];

  assign mwb_fwd_o = mwb_mem2reg_i ? mwb_rdata_i : mwb_alu_i;

  load_use_detect #(.AW(AW)) u_lud (
    .id_rs1_i   (id_rs1_i),
    .id_rs2_i   (id_rs2_i),
    .ex_rd_i    (ex_rd_i),
    .ex_memrd_i (ex_memrd_i),
    .stall_o    (stall)
  );

  assign pc_hold_o   = stall;
  assign ifid_hold_o = stall;
  assign ex_bubble_o = stall;

  always_comb begin
    // R7
    stall_agree_chk: assert (pc_hold_o == ifid_hold_o && ifid_hold_o == ex_bubble_o);
    // R5
    same_src_same_sel_chk: assert (!(ex_rs1_i == ex_rs2_i && fwd_a_o != fwd_b_o));
  end
endmodule

// File: tb/bypass_ctrl_test.sv
module bypass_ctrl_test;
  localparam int AW = 3;
  localparam int DW = 16;
  localparam int NREG = 1 << AW;
  localparam time CLK_PERIOD = 10;

  logic clk = 0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [AW-1:0] ex_rs1, ex_rs2, exm_rd, mwb_rd, id_rs1, id_rs2, ex_rd;
  logic          exm_we, mwb_we, mem2reg, ex_memrd;
  logic [DW-1:0] mwb_alu, mwb_rdata, mwb_fwd;
  logic [1:0]    fwd_a, fwd_b;
  logic          pc_hold, ifid_hold, ex_bubble;

  int checks = 0, fails = 0;
  bit done = 0;

  bypass_ctrl #(.AW(AW), .DW(DW)) uut (
    .ex_rs1_i(ex_rs1), .ex_rs2_i(ex_rs2), .exm_rd_i(exm_rd), .exm_we_i(exm_we),
    .mwb_rd_i(mwb_rd), .mwb_we_i(mwb_we), .mwb_mem2reg_i(mem2reg),
    .mwb_alu_i(mwb_alu), .mwb_rdata_i(mwb_rdata), .id_rs1_i(id_rs1), .id_rs2_i(id_rs2),
    .ex_rd_i(ex_rd), .ex_memrd_i(ex_memrd), .fwd_a_o(fwd_a), .fwd_b_o(fwd_b),
    .mwb_fwd_o(mwb_fwd), .pc_hold_o(pc_hold), .ifid_hold_o(ifid_hold), .ex_bubble_o(ex_bubble)
  );

  function automatic logic [1:0] exp_sel(int rs, int erd, bit ewe, int mrd, bit mwe);
    if (ewe && erd != 0 && erd == rs) return 2'b10;
    if (mwe && mrd != 0 && mrd == rs) return 2'b01;
    return 2'b00;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic settle();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    ex_rs1 = 0; ex_rs2 = 0; exm_rd = 0; mwb_rd = 0; id_rs1 = 0; id_rs2 = 0; ex_rd = 0;
    exm_we = 0; mwb_we = 0; mem2reg = 0; ex_memrd = 0; mwb_alu = 0; mwb_rdata = 0;
    settle();
    // idle state: R4, R8
    chk("R4 idle fwd_a", fwd_a, 2'b00);
    chk("R4 idle fwd_b", fwd_b, 2'b00);
    chk("R8 idle stall", {pc_hold, ifid_hold, ex_bubble}, 3'b000);

    // Full sweep of bypass selects: R1 R2 R3 R4 R5
    for (int rs = 0; rs < NREG; rs++)
      for (int erd = 0; erd < NREG; erd++)
        for (int mrd = 0; mrd < NREG; mrd++)
          for (int we = 0; we < 4; we++) begin
            int rs2 = (rs * 5 + 3) % NREG;
            logic [1:0] ea, eb;
            ex_rs1 = AW'(rs); ex_rs2 = AW'(rs2);
            exm_rd = AW'(erd); mwb_rd = AW'(mrd);
            exm_we = we[1]; mwb_we = we[0];
            settle();
            ea = exp_sel(rs, erd, we[1], mrd, we[0]);
            eb = exp_sel(rs2, erd, we[1], mrd, we[0]);
            if (ea == 2'b10 && we[0] && mrd == rs) chk("R3 priority a", fwd_a, ea);
            else if (ea == 2'b10) chk("R1 exm a", fwd_a, ea);
            else if (ea == 2'b01) chk("R2 mwb a", fwd_a, ea);
            else chk("R4 none a", fwd_a, ea);
            chk("R5 operand b", fwd_b, eb);
          end

    // R6 write-back value source
    for (int i = 0; i < 16; i++) begin
      mwb_alu = DW'(16'h1000 + i * 37);
      mwb_rdata = DW'(16'hA000 ^ (i * 91));
      mem2reg = i[0];
      settle();
      chk("R6 mwb value", mwb_fwd, i[0] ? 32'(mwb_rdata) : 32'(mwb_alu));
    end

    // Full sweep of load-use detection: R7 R8
    for (int a = 0; a < NREG; a++)
      for (int b = 0; b < NREG; b++)
        for (int d = 0; d < NREG; d++)
          for (int ld = 0; ld < 2; ld++) begin
            bit s;
            id_rs1 = AW'(a); id_rs2 = AW'(b); ex_rd = AW'(d); ex_memrd = ld[0];
            settle();
            s = ld[0] && d != 0 && (d == a || d == b);
            if (s) chk("R7 stall", {pc_hold, ifid_hold, ex_bubble}, 3'b111);
            else   chk("R8 no stall", {pc_hold, ifid_hold, ex_bubble}, 3'b000);
          end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule